// File: doc/BRIEF.md
# Single-Pass Scan ADC Sequencer

This block sequences one pass of analog-to-digital conversions over a group of channels. It sits between a small register bus and an abstract successive-approximation converter. Software first programs how many channels the pass covers and whether an interrupt is wanted. It then writes 1 to the go bit. From there the block works on its own. It requests a conversion on channel 0, waits for the converter's done handshake, and stores the result. It then moves up one channel at a time until it reaches the last selected channel.

Each 10-bit result is stored left-justified in a 16-bit per-channel data register. After the last channel the block does three things: it sets an end flag, clears its go bit by itself, and returns to standby. A further pass needs a new software start. The end flag holds until software clears it. An interrupt line follows the end flag when the interrupt enable is set.

The bus is a single-cycle write port plus a combinational read port. The register offsets are: control at 0, status at 1, and channel data registers at 4 to 7.

Top module: `scan_seq`

## Requirements
- R1: After synchronous active-low reset, every register reads 0, conv_start is 0 and irq is 0.
- R2: Writing a control word with bit 0 (go) equal to 1 while idle starts a pass. The first conversion request is a one-cycle conv_start pulse with conv_chan = 0.
- R3: Within a pass, channels are requested in ascending order from 0 up to the last channel. A new request comes only after the previous conv_done, so only one conversion is outstanding.
- R4: A result for channel c is read at offset 4+c with the 10-bit value in bits 15..6 and bits 5..0 equal to 0.
- R5: Control bits 2..1 give the last channel (0 to 3). Data registers of channels above it keep their previous values during the pass.
- R6: When the last channel's conv_done is taken, the following happen together:
  - status bit 0 (end flag) becomes 1;
  - control bit 0 reads 0;
  - no further conv_start is issued until a new start.
- R7: The end flag stays 1 until software writes status with bit 0 equal to 0. Writing 1 to it has no effect.
- R8: Writing go = 1 while a pass is running is ignored. The pass issues exactly one request per selected channel.
- R9: irq is 1 exactly while the end flag is 1 and control bit 3 (interrupt enable) is 1.
- R10: If a software clear of the end flag falls in the same cycle as the hardware end of pass, the flag ends up set.
- R11: Data registers keep their values until a later pass overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 2 | Channel of the current request |
| conv_done | input | 1 | Converter finished pulse |
| conv_result | input | 10 | Converter result, valid with conv_done |
| irq | output | 1 | End-of-pass interrupt |

## Verification
The two functions that can fall in the same cycle are the hardware end of pass, which sets the flag, and a software write that clears the flag. A stray start write can also meet the end of pass in that cycle. The bench's converter model provokes the clash by driving the status-clear write on the same clock edge as the last channel's conv_done. A correct block then reads the flag as 1, has dropped the go bit, and raises irq when enabled. A start write issued mid-pass is judged by counting requests, which must equal the number of selected channels.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and register offsets for the scan sequencer.
package scan_seq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd1;
    localparam int                DATA_BASE = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
`timescale 1ns/1ps
// Control and status registers.
// Holds the go bit, last channel, interrupt enable and end flag.
// Assumes pass_end is a one-cycle strobe from the sequencer.
// The hardware set of the end flag has priority over a software clear.
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CH_W+1:0]   wbits,
    input  logic              pass_end,
    output logic              go,
    output logic [CH_W-1:0]   last_ch,
    output logic              irq_en,
    output logic              end_flag
);
    logic wr_ctrl;
    logic wr_stat;

    assign wr_ctrl = wr_en && (addr == OFS_CTRL);
    assign wr_stat = wr_en && (addr == OFS_STAT);

    // Register updates: software fields, self-clearing go, sticky end flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go       <= 1'b0;
            last_ch  <= '0;
            irq_en   <= 1'b0;
            end_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                last_ch <= wbits[CH_W:1];
                irq_en  <= wbits[CH_W+1];
                if (wbits[0] && !go)
                    go <= 1'b1;
            end
            if (pass_end)
                go <= 1'b0;
            if (wr_stat && !wbits[0])
                end_flag <= 1'b0;
            if (pass_end)
                end_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/scan_seq_fsm.sv
`timescale 1ns/1ps
// Pass sequencer.
// Walks the channels from 0 to the latched last channel, one request at a time.
// Assumes conv_done arrives only while a request is outstanding.
module scan_seq_fsm
    import scan_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [CH_W-1:0] last_ch,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] cur_ch,
    output logic            store,
    output logic            pass_end
);
    seq_state_t      state;
    logic [CH_W-1:0] last_q;

    // Request in REQ, capture the result on done in WAIT.
    assign conv_start = (state == ST_REQ);
    assign store      = (state == ST_WAIT) && conv_done;
    assign pass_end   = store && (cur_ch == last_q);

    // State, channel pointer and latched pass length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
            last_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    state  <= ST_REQ;
                    cur_ch <= '0;
                    last_q <= last_ch;
                end
                ST_REQ:  state <= ST_WAIT;
                ST_WAIT: if (conv_done) begin
                    if (cur_ch == last_q) begin
                        state <= ST_IDLE;
                    end else begin
                        cur_ch <= cur_ch + 1'b1;
                        state  <= ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scan_seq_data.sv
`timescale 1ns/1ps
// Per-channel result registers.
// A result is stored left-justified, with the low bits zero.
// A register holds its value until the next store to its channel.
module scan_seq_data #(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  store,
    input  logic [CH_W-1:0]       cur_ch,
    input  logic [RES_W-1:0]      result,
    output logic [NCH*DATA_W-1:0] data_flat
);
    localparam int PAD_W = DATA_W - RES_W;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Result register of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_flat[c*DATA_W +: DATA_W] <= '0;
            else if (store && (cur_ch == CH_W'(c)))
                data_flat[c*DATA_W +: DATA_W] <= {result, {PAD_W{1'b0}}};
        end
    end
endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
// Single-pass scan ADC sequencer, top level.
// Joins the control registers, the sequencer and the result registers.
// The read port is combinational.
module scan_seq
    import scan_seq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    logic                  go;
    logic [CH_W-1:0]       last_ch;
    logic                  irq_en;
    logic                  end_flag;
    logic                  store;
    logic                  pass_end;
    logic [NCH*DATA_W-1:0] data_flat;

    scan_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wbits    (wdata[CH_W+1:0]),
        .pass_end (pass_end),
        .go       (go),
        .last_ch  (last_ch),
        .irq_en   (irq_en),
        .end_flag (end_flag)
    );

    scan_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .last_ch    (last_ch),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .cur_ch     (conv_chan),
        .store      (store),
        .pass_end   (pass_end)
    );

    scan_seq_data #(.NCH(NCH), .CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (store),
        .cur_ch    (conv_chan),
        .result    (conv_result),
        .data_flat (data_flat)
    );

    assign irq = end_flag && irq_en;

    // Read multiplexer over control, status and data registers.
    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) begin
            rdata[0]        = go;
            rdata[CH_W:1]   = last_ch;
            rdata[CH_W+1]   = irq_en;
        end else if (addr == OFS_STAT) begin
            rdata[0] = end_flag;
        end else begin
            for (int c = 0; c < NCH; c++)
                if (addr == ADDR_W'(DATA_BASE + c))
                    rdata = data_flat[c*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/scan_seq_chk.sv
`timescale 1ns/1ps
// Protocol and register checker, bound into scan_seq.
// Tracks the outstanding request itself to judge the converter handshake.
module scan_seq_chk #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic            conv_done,
    input logic            go,
    input logic            end_flag,
    input logic            pass_end,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic [CH_W+1:0] wbits
);
    logic pend;

    // Outstanding-request tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (conv_start)
            pend <= 1'b1;
        else if (conv_done)
            pend <= 1'b0;
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pend);

    assert_end_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> (end_flag && !go));

    assert_idle_no_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> !conv_start);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && !(wr_en && addr == 3'd1 && !wbits[0])) |=> end_flag);

    assert_go_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !pass_end) |=> go);
endmodule

bind scan_seq scan_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .go         (go),
    .end_flag   (end_flag),
    .pass_end   (pass_end),
    .wr_en      (wr_en),
    .addr       (addr),
    .wbits      (wdata[CH_W+1:0])
);

// File: tb/scan_seq_test.sv
`timescale 1ns/1ps
module scan_seq_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        conv_start;
    logic [1:0]  conv_chan;
    logic        conv_done = 0;
    logic [9:0]  conv_result = 0;
    logic        irq;

    int checks = 0, errors = 0;
    int nstarts = 0, nconv = 0, pass_no = 0;
    int last_cfg = 0, lat_cfg = 0;
    bit clash_cfg = 0, ones_cfg = 0;
    logic [15:0] exp_data [4] = '{default: 16'h0};

    scan_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    // Converter model: answers each request after lat_cfg idle cycles.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (conv_start) begin
                automatic logic [1:0] ch = conv_chan;
                automatic logic [9:0] res;
                chk(ch == 2'(nstarts), "R3 channel order", 16'(ch), 16'(nstarts));
                nstarts++;
                for (int i = 0; i < lat_cfg; i++) begin
                    @(negedge clk); #1;
                    chk(!conv_start, "R3 request while outstanding", 16'(conv_start), 16'h0);
                end
                @(negedge clk);
                res = ones_cfg ? 10'h3FF : 10'((int'(ch) * 293 + pass_no * 157 + 3) % 1024);
                conv_result = res;
                conv_done = 1;
                exp_data[ch] = {res, 6'b0};
                if (clash_cfg && int'(ch) == last_cfg) begin
                    wr_en = 1; addr = 3'd1; wdata = 16'h0;
                end
                nconv++;
                @(posedge clk); #1;
                conv_done = 0;
                if (clash_cfg) wr_en = 0;
            end
        end
    end

    task automatic run_scan(input int last, input int lat, input bit ie, input bit restart,
                            input bit clash, input bit ones);
        logic [15:0] d;
        last_cfg = last; lat_cfg = lat; clash_cfg = clash; ones_cfg = ones;
        nstarts = 0; nconv = 0; pass_no++;
        wr(3'd0, 16'((int'(ie) << 3) | (last << 1) | 1));
        if (restart) begin
            wait (nconv >= 1);
            wr(3'd0, 16'((int'(ie) << 3) | (last << 1) | 1));
        end
        wait (nconv == last + 1);
        repeat (8) @(negedge clk);
        chk(nstarts == last + 1, restart ? "R8 requests per pass" : "R6 one request per channel",
            16'(nstarts), 16'(last + 1));
        rd(3'd0, d);
        chk(d[0] == 1'b0, "R6 go self-cleared", d, {d[15:1], 1'b0});
        chk(d[2:1] == 2'(last), "R5 last field", 16'(d[2:1]), 16'(last));
        rd(3'd1, d);
        chk(d == 16'h1, clash ? "R10 set wins over clear" : "R6 end flag set", d, 16'h1);
        chk(irq == ie, "R9 irq with flag", 16'(irq), 16'(ie));
        for (int c = 0; c < 4; c++) begin
            rd(3'(4 + c), d);
            chk(d == exp_data[c], c <= last ? "R4 result placement" : "R5 R11 untouched channel",
                d, exp_data[c]);
        end
        wr(3'd1, 16'h1);
        rd(3'd1, d);
        chk(d == 16'h1, "R7 write 1 keeps flag", d, 16'h1);
        wr(3'd1, 16'h0);
        rd(3'd1, d);
        chk(d == 16'h0, "R7 write 0 clears flag", d, 16'h0);
        chk(irq == 1'b0, "R9 irq drops", 16'(irq), 16'h0);
        chk(nstarts == last + 1, "R6 no request after pass", 16'(nstarts), 16'(last + 1));
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 16'h0, "R1 register reset", d, 16'h0);
        end
        chk(conv_start == 0 && irq == 0, "R1 outputs reset", {14'b0, conv_start, irq}, 16'h0);
        for (int last = 0; last < 4; last++)
            for (int lat = 0; lat < 3; lat++)
                run_scan(last, lat, lat[0], 0, 0, 0);
        run_scan(0, 1, 1, 0, 0, 0);
        run_scan(3, 2, 0, 1, 0, 0);
        run_scan(3, 0, 1, 0, 0, 1);
        run_scan(1, 1, 1, 0, 1, 0);
        run_scan(2, 3, 0, 0, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule